// File: doc/BRIEF.md
# Page Keeper Recovery Controller

This controller sits at the processor that keeps a page and serves one page-level coherence recovery at a time. A request carries a page number and the identity of the processor that started the recovery. When a request is accepted, the controller locks the page's translation entry. It then probes the local cache for each block of the page in turn and records the resident ones in a presence vector with one bit per block.

Once the vector is complete, the controller waits until the miss-handling registers report no outstanding operation on that page. Only then does it send a response carrying the page and the vector to the page's home controller. When the home side confirms with a target-done message, the controller does three things: it marks the translation entry as shared, releases the lock, and offers a recovery-done notification addressed to the initiator.

The cache array, the translation storage, the miss-handling registers and the network are outside this block. Each of them is reached through a plain request or response port.

Top module: `page_recovery_keeper`

## Requirements
- R1: Reset state. While reset is held and in the first cycle after it, `req_ready` is 1 and `tlb_lock`, `probe_valid`, `resp_valid`, `tlb_mark_shared` and `done_valid` are 0.
- R2: A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1. From the next cycle, `tlb_lock` is 1 and `tlb_page` shows the accepted page. The lock stays high until the target-done message is taken.
- R3: From the cycle after acceptance, `probe_valid` is 1 for exactly BLOCKS consecutive cycles. During these cycles `probe_idx` runs 0, 1, …, BLOCKS-1, one index per cycle, and `probe_page` shows the locked page.
- R4: Bit i of `resp_vec` equals the `probe_hit` value returned in the cycle when `probe_idx` was i. With the default parameters the vector is 64 bits wide, and bit 0 is block 0.
- R5: After the last probe, the controller spends at least one cycle checking `mshr_busy`. `resp_valid` rises in the cycle after the first checking cycle in which `mshr_busy` is 0, and never earlier.
- R6: `resp_valid` stays high with `resp_page` and `resp_vec` stable until a cycle in which `resp_ready` is 1.
- R7: While the controller waits for the home side, a cycle with `tdone_valid` high makes `tlb_mark_shared` 1 in that same cycle. In the next cycle `tlb_lock` is 0 and `done_valid` is 1, with `done_dst` equal to the initiator identity of the request.
- R8: `tdone_valid` has no effect in any state other than waiting for the home side. `tlb_mark_shared` stays 0 and the sequence does not advance.
- R9: `req_ready` is 1 only when no recovery is in progress. A request held at `req_valid` is stalled, and it is accepted on the first edge after the controller returns to idle.
- R10: `done_valid` stays high until a cycle with `done_ready` high. In the following cycle `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Recovery request present |
| req_ready | output | 1 | Controller idle, request can be taken |
| req_page | input | PAGE_W | Page number to recover |
| req_src | input | SRC_W | Initiator identity |
| tlb_lock | output | 1 | Translation entry of `tlb_page` locked |
| tlb_mark_shared | output | 1 | One-cycle command to mark `tlb_page` shared |
| tlb_page | output | PAGE_W | Page under recovery |
| probe_valid | output | 1 | Cache probe issued |
| probe_page | output | PAGE_W | Page of the probed block |
| probe_idx | output | IDX_W | Block index within the page |
| probe_hit | input | 1 | Probed block resident (same cycle) |
| mshr_page | output | PAGE_W | Page queried in the miss-handling registers |
| mshr_busy | input | 1 | Outstanding operation on `mshr_page` |
| resp_valid | output | 1 | Response to the home controller present |
| resp_ready | input | 1 | Response taken |
| resp_page | output | PAGE_W | Page in the response |
| resp_vec | output | BLOCKS | Block presence vector |
| tdone_valid | input | 1 | Target-done message from the home side |
| done_valid | output | 1 | Recovery-done notification present |
| done_ready | input | 1 | Notification taken |
| done_dst | output | SRC_W | Initiator the notification goes to |

## Verification
Two events can land in the same cycle. The first pair is the final handshake of one recovery and a new request that is already waiting. The bench holds a second request at `req_valid` through the whole first recovery, including the `done_ready` cycle. The reference model expects `req_ready` low in that cycle and acceptance on the next edge. The second pair is a target-done message and the response phase. A stray `tdone_valid` pulse is driven while the response is still unaccepted, and the bench checks every cycle that `tlb_mark_shared` stays low and the response stays up.

// File: rtl/pkr_pkg.sv
package pkr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_SCAN   = 3'd1,
        ST_DRAIN  = 3'd2,
        ST_SEND   = 3'd3,
        ST_WAIT   = 3'd4,
        ST_NOTIFY = 3'd5
    } pkr_state_e;

endpackage

// File: rtl/pkr_scan.sv
module pkr_scan #(
    parameter int BLOCKS = 64,
    localparam int IDX_W = (BLOCKS > 1) ? $clog2(BLOCKS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              probe_hit,
    output logic              probe_valid,
    output logic [IDX_W-1:0]  probe_idx,
    output logic              scan_done,
    output logic [BLOCKS-1:0] vec
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BLOCKS - 1);

    typedef struct packed {
        logic              active;
        logic [IDX_W-1:0]  idx;
        logic [BLOCKS-1:0] vec;
    } scan_s;

    scan_s s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (start) begin
            s_d.active = 1'b1;
            s_d.idx    = '0;
            s_d.vec    = '0;
        end else if (s_q.active) begin
            s_d.vec[s_q.idx] = probe_hit;
            if (s_q.idx == LAST_IDX) begin
                s_d.active = 1'b0;
            end else begin
                s_d.idx = s_q.idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign probe_valid = s_q.active;
    assign probe_idx   = s_q.idx;
    assign scan_done   = s_q.active && (s_q.idx == LAST_IDX);
    assign vec         = s_q.vec;

    // R3: consecutive probes step the index by one
    a_r3_idx_step: assert property (@(posedge clk) disable iff (!rst_n)
        (probe_valid && $past(probe_valid)) |-> (probe_idx == $past(probe_idx) + 1'b1));

    // R3: a scan always begins at index 0
    a_r3_start_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(probe_valid) |-> (probe_idx == '0));

endmodule

// File: rtl/pkr_ctrl.sv
module pkr_ctrl
    import pkr_pkg::*;
#(
    parameter int PAGE_W = 20,
    parameter int SRC_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [PAGE_W-1:0] req_page,
    input  logic [SRC_W-1:0]  req_src,
    output logic              req_ready,
    output logic              scan_start,
    input  logic              scan_done,
    input  logic              mshr_busy,
    output logic              resp_valid,
    input  logic              resp_ready,
    input  logic              tdone_valid,
    output logic              mark_shared,
    output logic              done_valid,
    input  logic              done_ready,
    output logic              lock,
    output logic [PAGE_W-1:0] cur_page,
    output logic [SRC_W-1:0]  cur_src
);

    typedef struct packed {
        pkr_state_e        state;
        logic [PAGE_W-1:0] page;
        logic [SRC_W-1:0]  src;
    } ctrl_s;

    ctrl_s c_d, c_q;

    always_comb begin
        c_d         = c_q;
        scan_start  = 1'b0;
        mark_shared = 1'b0;
        unique case (c_q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    c_d.page   = req_page;
                    c_d.src    = req_src;
                    c_d.state  = ST_SCAN;
                    scan_start = 1'b1;
                end
            end
            ST_SCAN: begin
                if (scan_done) c_d.state = ST_DRAIN;
            end
            ST_DRAIN: begin
                if (!mshr_busy) c_d.state = ST_SEND;
            end
            ST_SEND: begin
                if (resp_ready) c_d.state = ST_WAIT;
            end
            ST_WAIT: begin
                if (tdone_valid) begin
                    mark_shared = 1'b1;
                    c_d.state   = ST_NOTIFY;
                end
            end
            ST_NOTIFY: begin
                if (done_ready) c_d.state = ST_IDLE;
            end
            default: c_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q <= '{state: ST_IDLE, page: '0, src: '0};
        end else begin
            c_q <= c_d;
        end
    end

    assign req_ready  = (c_q.state == ST_IDLE);
    assign resp_valid = (c_q.state == ST_SEND);
    assign done_valid = (c_q.state == ST_NOTIFY);
    assign lock       = (c_q.state != ST_IDLE) && (c_q.state != ST_NOTIFY);
    assign cur_page   = c_q.page;
    assign cur_src    = c_q.src;

    // R2: acceptance locks the entry in the next cycle
    a_r2_lock_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> lock);

    // R9: no acceptance while the entry is locked
    a_r9_ready_idle_only: assert property (@(posedge clk) disable iff (!rst_n)
        lock |-> !req_ready);

    // R7: target-done leads to release and notification
    a_r7_release_notify: assert property (@(posedge clk) disable iff (!rst_n)
        mark_shared |=> (!lock && done_valid));

    // R10: notification held until taken
    a_r10_done_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid && !done_ready) |=> (done_valid && $stable(cur_src)));

endmodule

// File: rtl/page_recovery_keeper.sv
module page_recovery_keeper #(
    parameter int PAGE_W = 20,
    parameter int SRC_W  = 4,
    parameter int BLOCKS = 64,
    localparam int IDX_W = (BLOCKS > 1) ? $clog2(BLOCKS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [PAGE_W-1:0] req_page,
    input  logic [SRC_W-1:0]  req_src,
    output logic              tlb_lock,
    output logic              tlb_mark_shared,
    output logic [PAGE_W-1:0] tlb_page,
    output logic              probe_valid,
    output logic [PAGE_W-1:0] probe_page,
    output logic [IDX_W-1:0]  probe_idx,
    input  logic              probe_hit,
    output logic [PAGE_W-1:0] mshr_page,
    input  logic              mshr_busy,
    output logic              resp_valid,
    input  logic              resp_ready,
    output logic [PAGE_W-1:0] resp_page,
    output logic [BLOCKS-1:0] resp_vec,
    input  logic              tdone_valid,
    output logic              done_valid,
    input  logic              done_ready,
    output logic [SRC_W-1:0]  done_dst
);

    logic              scan_start;
    logic              scan_done;
    logic [PAGE_W-1:0] cur_page;

    pkr_ctrl #(
        .PAGE_W (PAGE_W),
        .SRC_W  (SRC_W)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_page    (req_page),
        .req_src     (req_src),
        .req_ready   (req_ready),
        .scan_start  (scan_start),
        .scan_done   (scan_done),
        .mshr_busy   (mshr_busy),
        .resp_valid  (resp_valid),
        .resp_ready  (resp_ready),
        .tdone_valid (tdone_valid),
        .mark_shared (tlb_mark_shared),
        .done_valid  (done_valid),
        .done_ready  (done_ready),
        .lock        (tlb_lock),
        .cur_page    (cur_page),
        .cur_src     (done_dst)
    );

    pkr_scan #(
        .BLOCKS (BLOCKS)
    ) u_scan (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (scan_start),
        .probe_hit   (probe_hit),
        .probe_valid (probe_valid),
        .probe_idx   (probe_idx),
        .scan_done   (scan_done),
        .vec         (resp_vec)
    );

    assign tlb_page   = cur_page;
    assign probe_page = cur_page;
    assign mshr_page  = cur_page;
    assign resp_page  = cur_page;

    // R5: a response only follows a cycle with no outstanding miss
    a_r5_after_drain: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(resp_valid) |-> $past(!mshr_busy));

    // R6: response held stable until taken
    a_r6_resp_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && !resp_ready) |=> (resp_valid && $stable(resp_vec) && $stable(resp_page)));

    // R3: probes only while the entry is locked
    a_r3_probe_locked: assert property (@(posedge clk) disable iff (!rst_n)
        probe_valid |-> tlb_lock);

    // R8: target-done outside the wait phase changes nothing
    a_r8_tdone_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (tdone_valid && (resp_valid || probe_valid)) |-> !tlb_mark_shared);

endmodule

// File: tb/page_recovery_keeper_tb.sv
module page_recovery_keeper_tb;

    localparam int PAGE_W = 20;
    localparam int SRC_W  = 4;
    localparam int BLOCKS = 64;
    localparam int IDX_W  = 6;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [PAGE_W-1:0] req_page = '0;
    logic [SRC_W-1:0]  req_src = '0;
    logic              tlb_lock, tlb_mark_shared;
    logic [PAGE_W-1:0] tlb_page;
    logic              probe_valid;
    logic [PAGE_W-1:0] probe_page;
    logic [IDX_W-1:0]  probe_idx;
    logic              probe_hit;
    logic [PAGE_W-1:0] mshr_page;
    logic              mshr_busy = 1'b0;
    logic              resp_valid;
    logic              resp_ready = 1'b0;
    logic [PAGE_W-1:0] resp_page;
    logic [BLOCKS-1:0] resp_vec;
    logic              tdone_valid = 1'b0;
    logic              done_valid;
    logic              done_ready = 1'b0;
    logic [SRC_W-1:0]  done_dst;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    logic timeout = 1'b0;

    always #5 clk = ~clk;

    page_recovery_keeper #(.PAGE_W(PAGE_W), .SRC_W(SRC_W), .BLOCKS(BLOCKS)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_page(req_page), .req_src(req_src), .tlb_lock(tlb_lock),
        .tlb_mark_shared(tlb_mark_shared), .tlb_page(tlb_page),
        .probe_valid(probe_valid), .probe_page(probe_page), .probe_idx(probe_idx),
        .probe_hit(probe_hit), .mshr_page(mshr_page), .mshr_busy(mshr_busy),
        .resp_valid(resp_valid), .resp_ready(resp_ready), .resp_page(resp_page),
        .resp_vec(resp_vec), .tdone_valid(tdone_valid), .done_valid(done_valid),
        .done_ready(done_ready), .done_dst(done_dst)
    );

    // cache model: page 1 fully resident, page 2 empty, others mixed
    function automatic logic hit_of(input logic [PAGE_W-1:0] pg, input int idx);
        if (pg == 20'd1) return 1'b1;
        if (pg == 20'd2) return 1'b0;
        return ((int'(pg) + idx * idx) % 3) == 0;
    endfunction

    assign probe_hit = probe_valid ? hit_of(probe_page, int'(probe_idx)) : 1'b0;

    // behavioural reference: phase 0 idle,1 probing,2 waiting misses,3 responding,4 home wait,5 notify
    int               m_phase = 0;
    int               m_idx = 0;
    logic [63:0]      m_vec = '0;
    logic [PAGE_W-1:0] m_page = '0;
    logic [SRC_W-1:0] m_src = '0;

    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            m_phase = 0; m_idx = 0; m_vec = '0; m_page = '0; m_src = '0;
        end else begin
            case (m_phase)
                0: if (req_valid) begin
                       m_page = req_page; m_src = req_src; m_idx = 0; m_vec = '0; m_phase = 1;
                   end
                1: begin
                       m_vec[m_idx] = hit_of(m_page, m_idx);
                       if (m_idx == BLOCKS - 1) m_phase = 2; else m_idx++;
                   end
                2: if (!mshr_busy) m_phase = 3;
                3: if (resp_ready) m_phase = 4;
                4: if (tdone_valid) m_phase = 5;
                5: if (done_ready) m_phase = 0;
                default: m_phase = 0;
            endcase
        end
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            chk("R9 req_ready", 64'(req_ready), 64'(m_phase == 0));
            chk("R2 tlb_lock", 64'(tlb_lock), 64'(m_phase >= 1 && m_phase <= 4));
            chk("R3 probe_valid", 64'(probe_valid), 64'(m_phase == 1));
            chk("R5 resp_valid", 64'(resp_valid), 64'(m_phase == 3));
            chk("R7 R8 tlb_mark_shared", 64'(tlb_mark_shared), 64'(m_phase == 4 && tdone_valid));
            chk("R10 done_valid", 64'(done_valid), 64'(m_phase == 5));
            if (m_phase >= 1 && m_phase <= 4) begin
                chk("R2 tlb_page", 64'(tlb_page), 64'(m_page));
                chk("R5 mshr_page", 64'(mshr_page), 64'(m_page));
            end
            if (m_phase == 1) begin
                chk("R3 probe_idx", 64'(probe_idx), 64'(m_idx));
                chk("R3 probe_page", 64'(probe_page), 64'(m_page));
            end
            if (m_phase == 3) begin
                chk("R4 resp_vec", 64'(resp_vec), m_vec);
                chk("R6 resp_page", 64'(resp_page), 64'(m_page));
            end
            if (m_phase == 5) chk("R7 done_dst", 64'(done_dst), 64'(m_src));
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic recover(input logic [PAGE_W-1:0] pg, input logic [SRC_W-1:0] src,
                           input int busy_cycles, input int resp_delay, input int done_delay,
                           input bit queue_next, input logic [PAGE_W-1:0] next_pg);
        logic acc;
        req_page = pg; req_src = src; req_valid = 1'b1;
        mshr_busy = (busy_cycles > 0);
        do begin
            acc = req_ready;
            step();
        end while (!acc);
        if (queue_next) begin
            req_page = next_pg; req_src = src + 1'b1;   // R9: held through the whole recovery
        end else begin
            req_valid = 1'b0;
        end
        repeat (BLOCKS + busy_cycles) step();
        mshr_busy = 1'b0;
        while (!resp_valid) step();
        if (resp_delay > 0) begin
            tdone_valid = 1'b1;                          // R8: stray target-done
            step();
            tdone_valid = 1'b0;
            repeat (resp_delay - 1) step();
        end
        resp_ready = 1'b1; step(); resp_ready = 1'b0;
        repeat (3) step();
        tdone_valid = 1'b1; step(); tdone_valid = 1'b0;
        while (!done_valid) step();
        repeat (done_delay) step();
        done_ready = 1'b1; step(); done_ready = 1'b0;
    endtask

    initial begin
        fork
            begin
                repeat (3) step();
                // R1: reset state
                chk("R1 req_ready", 64'(req_ready), 64'd1);
                chk("R1 idle outputs", 64'({tlb_lock, probe_valid, resp_valid, tlb_mark_shared, done_valid}), 64'd0);
                rst_n = 1'b1;
                #4;
                chk("R1 req_ready after reset", 64'(req_ready), 64'd1);
                chk("R1 lock after reset", 64'(tlb_lock), 64'd0);
                step();
                recover(20'd1, 4'd3, 0, 0, 0, 1'b0, '0);
                recover(20'd2, 4'd5, 10, 4, 2, 1'b0, '0);
                recover(20'h12345, 4'd7, 3, 1, 3, 1'b1, 20'h00abc);
                recover(20'h00abc, 4'd8, 0, 2, 0, 1'b0, '0);
                repeat (5) step();
                chk("R10 idle at end", 64'(req_ready), 64'd1);
            end
            begin
                wait (cycles > 20000);
                timeout = 1'b1;
            end
        join_any
        if (timeout) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule